// File: doc/BRIEF.md
# Dual-Direction UART with Gated Interrupt Flags

This block holds a serial receiver and a serial transmitter that both run from one shared 16x oversampling tick. Each direction has a module enable, a status flag and an interrupt-enable bit, and each drives its own interrupt request. The request is high only while the flag and its interrupt enable are both set. A host programs the block through a small register port. Separate write strobes load the mode bits, the interrupt-enable bits and the transmit byte, and a read strobe acknowledges the received byte.

The receiver is a small state machine. While enabled it waits for a start bit and checks it at mid-bit. It then collects one character and posts it. Turning the receiver off while a character is arriving does not cut the character short. An optional line-quiet mode makes a freshly enabled receiver wait for a long stretch of high line before it trusts any start bit. There are two synchronous resets. The power-up clear resets everything. The software reset leaves the enable bits alone.

Top module: `uart_irq_pair`

## Requirements
- R1: After `por`, `mode_q` and `ie_q` are 0, `rx_flag` is 0, `tx_flag` is 1 and `txd` is 1.
- R2: A `sw_rst` pulse clears `rx_flag` and `ie_q`, sets `tx_flag`, aborts any frame so `txd` returns to 1, and leaves `mode_q` unchanged.
- R3: The receive frame is a low start bit, 8 data bits LSB first, then one stop bit, each 16 ticks long. When the character completes, `rx_data` is loaded and `rx_flag` is set. A `rd_rxdata` pulse clears `rx_flag`.
- R4: A start bit counts as valid only if `rxd` is still low 8 ticks after the falling edge is seen. A shorter low pulse returns the receiver to idle without setting `rx_flag`, and the next frame is received normally.
- R5: Clearing the receive enable (`mode_wdata` bit 0) while a character is arriving lets that character finish and post. After that the receiver is off, and a later frame leaves `rx_flag` at 0 and `rx_data` unchanged.
- R6: While the receive enable is 0 and no character is in progress, a start bit is ignored: `rx_active` stays 0 and `rx_flag` stays 0.
- R7: With the line-quiet mode set (`mode_wdata` bit 2), an enabled receiver accepts a start bit only after `rxd` has been high for 160 consecutive ticks (10 bit times). A low tick restarts that count.
- R8: A `wr_txdata` pulse clears `tx_flag` on the next cycle. `tx_flag` is set again in the cycle after the byte moves into the shift register. That happens one cycle after the write when the transmit enable (`mode_wdata` bit 1) is 1 and the shifter is idle. With the transmit enable at 0, the byte waits and `tx_flag` stays 0.
- R9: `txd` idles at 1. A frame is a low start bit, 8 data bits LSB first, then a high stop bit, each 16 ticks long.
- R10: `rx_irq` is `rx_flag` AND `ie_q` bit 0, and `tx_irq` is `tx_flag` AND `ie_q` bit 1. `ie_wdata` uses the same bit positions.
- R11: The receiver and the transmitter run at the same time without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-up clear, synchronous, active high |
| sw_rst | input | 1 | Software reset, synchronous, active high |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| wr_mode | input | 1 | Write strobe for the mode bits |
| mode_wdata | input | 3 | Bit 0 receive enable, bit 1 transmit enable, bit 2 line-quiet mode |
| wr_ie | input | 1 | Write strobe for the interrupt enables |
| ie_wdata | input | 2 | Bit 0 receive interrupt enable, bit 1 transmit interrupt enable |
| wr_txdata | input | 1 | Write strobe for the transmit byte |
| tx_wdata | input | 8 | Transmit byte |
| rd_rxdata | input | 1 | Read strobe that acknowledges the received byte |
| rx_data | output | 8 | Last received byte |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| mode_q | output | 3 | Current mode bits |
| ie_q | output | 2 | Current interrupt enables |
| rx_flag | output | 1 | Received byte waiting |
| tx_flag | output | 1 | Transmit buffer free |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_active | output | 1 | Receiver is checking a start bit or collecting a character |

## Verification
Register-port results show up one cycle after the strobe. So every write or read task releases its strobe at the next falling edge and checks there. A transmit load shows on `tx_flag` and on `txd` one cycle after that. Serial results depend on the tick phase: a received byte posts about mid-way through its stop bit, and transmit bits last 16 ticks. The bench therefore reads receive results a few cycles after its own stop bit ends, and it samples `txd` at bit centres counted from the observed falling edge. The line-quiet and glitch cases keep their idle gaps well clear of the 160-tick and 8-tick thresholds.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int OVS_DEF       = 16;
    localparam int DATA_BITS_DEF = 8;
    localparam int IDLE_BITS_DEF = 10;

    typedef enum logic [2:0] {
        RX_OFF,
        RX_HUNT,
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    // bit 2: line-quiet mode, bit 1: tx enable, bit 0: rx enable
    typedef struct packed {
        logic idle_wait;
        logic tx_en;
        logic rx_en;
    } mode_t;

    // bit 1: tx interrupt enable, bit 0: rx interrupt enable
    typedef struct packed {
        logic tx_ie;
        logic rx_ie;
    } ie_t;

    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       por,
    input  logic       sw_rst,
    input  logic       wr_mode,
    input  logic [2:0] mode_wdata,
    input  logic       wr_ie,
    input  logic [1:0] ie_wdata,
    input  logic       rx_done,
    input  logic       rd_rx,
    input  logic       tx_wr,
    input  logic       tx_load,
    output mode_t      mode,
    output ie_t        ie,
    output logic       rx_flag,
    output logic       tx_flag
);

    // Enables survive the software reset; only power-up clears them.
    always_ff @(posedge clk) begin
        if (por)          mode <= '0;
        else if (wr_mode) mode <= mode_t'(mode_wdata);
    end

    always_ff @(posedge clk) begin
        if (por || sw_rst) begin
            ie      <= '0;
            rx_flag <= 1'b0;
            tx_flag <= 1'b1;
        end else begin
            if (wr_ie) ie <= ie_t'(ie_wdata);
            if (rx_done)    rx_flag <= 1'b1;
            else if (rd_rx) rx_flag <= 1'b0;
            if (tx_wr)        tx_flag <= 1'b0;
            else if (tx_load) tx_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/uart_irq_rx.sv
module uart_irq_rx
    import uart_irq_pkg::*;
#(
    parameter int OVS       = OVS_DEF,
    parameter int DATA_BITS = DATA_BITS_DEF,
    parameter int IDLE_BITS = IDLE_BITS_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 en,
    input  logic                 idle_wait,
    input  logic                 rxd,
    output logic                 done,
    output logic                 active,
    output logic [DATA_BITS-1:0] data
);

    localparam int HALF   = OVS / 2;
    localparam int HUNT_N = IDLE_BITS * OVS;
    localparam int TW     = cnt_w(OVS);
    localparam int BW     = cnt_w(DATA_BITS);
    localparam int HW     = cnt_w(HUNT_N);

    rx_state_e              state;
    logic [TW-1:0]          tcnt;
    logic [BW-1:0]          bcnt;
    logic [HW-1:0]          hunt;
    logic [DATA_BITS-1:0]   shreg;
    logic [1:0]             sync;
    logic                   rx_s;

    assign rx_s   = sync[1];
    assign active = (state == RX_START) || (state == RX_DATA) || (state == RX_STOP);
    assign done   = (state == RX_STOP) && tick && (tcnt == TW'(OVS - 1));

    always_ff @(posedge clk) begin
        if (rst) sync <= 2'b11;
        else     sync <= {sync[0], rxd};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RX_OFF;
            tcnt  <= '0;
            bcnt  <= '0;
            hunt  <= '0;
            shreg <= '0;
            data  <= '0;
        end else begin
            case (state)
                RX_OFF: begin
                    hunt <= '0;
                    if (en) state <= idle_wait ? RX_HUNT : RX_IDLE;
                end
                RX_HUNT: begin
                    if (!en) state <= RX_OFF;
                    else if (tick) begin
                        if (!rx_s)                    hunt  <= '0;
                        else if (hunt == HW'(HUNT_N - 1)) state <= RX_IDLE;
                        else                          hunt  <= hunt + 1'b1;
                    end
                end
                RX_IDLE: begin
                    if (!en) state <= RX_OFF;
                    else if (tick && !rx_s) begin
                        state <= RX_START;
                        tcnt  <= '0;
                    end
                end
                RX_START: if (tick) begin
                    if (tcnt == TW'(HALF - 1)) begin
                        tcnt <= '0;
                        bcnt <= '0;
                        if (!rx_s) state <= RX_DATA;
                        else       state <= en ? RX_IDLE : RX_OFF;
                    end else tcnt <= tcnt + 1'b1;
                end
                RX_DATA: if (tick) begin
                    if (tcnt == TW'(OVS - 1)) begin
                        tcnt  <= '0;
                        shreg <= {rx_s, shreg[DATA_BITS-1:1]};
                        if (bcnt == BW'(DATA_BITS - 1)) state <= RX_STOP;
                        else                            bcnt  <= bcnt + 1'b1;
                    end else tcnt <= tcnt + 1'b1;
                end
                RX_STOP: if (tick) begin
                    if (tcnt == TW'(OVS - 1)) begin
                        tcnt  <= '0;
                        data  <= shreg;
                        state <= en ? RX_IDLE : RX_OFF;
                    end else tcnt <= tcnt + 1'b1;
                end
                default: state <= RX_OFF;
            endcase
        end
    end

endmodule

// File: rtl/uart_irq_tx.sv
module uart_irq_tx
    import uart_irq_pkg::*;
#(
    parameter int OVS       = OVS_DEF,
    parameter int DATA_BITS = DATA_BITS_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 en,
    input  logic                 wr,
    input  logic [DATA_BITS-1:0] wdata,
    output logic                 load,
    output logic                 txd
);

    localparam int FRAME = DATA_BITS + 2;
    localparam int TW    = cnt_w(OVS);
    localparam int BW    = cnt_w(FRAME);

    logic [DATA_BITS-1:0] buf_q;
    logic                 buf_full;
    logic                 busy;
    logic [FRAME-1:0]     sh;
    logic [TW-1:0]        tcnt;
    logic [BW-1:0]        bcnt;

    assign load = buf_full && en && !busy;
    assign txd  = sh[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q    <= '0;
            buf_full <= 1'b0;
        end else if (wr) begin
            buf_q    <= wdata;
            buf_full <= 1'b1;
        end else if (load) begin
            buf_full <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            sh   <= '1;
            tcnt <= '0;
            bcnt <= '0;
        end else if (load) begin
            busy <= 1'b1;
            sh   <= {1'b1, buf_q, 1'b0};
            tcnt <= '0;
            bcnt <= '0;
        end else if (busy && tick) begin
            if (tcnt == TW'(OVS - 1)) begin
                tcnt <= '0;
                sh   <= {1'b1, sh[FRAME-1:1]};
                if (bcnt == BW'(FRAME - 1)) busy <= 1'b0;
                else                        bcnt <= bcnt + 1'b1;
            end else tcnt <= tcnt + 1'b1;
        end
    end

endmodule

// File: rtl/uart_irq_pair.sv
module uart_irq_pair
    import uart_irq_pkg::*;
#(
    parameter int OVS       = OVS_DEF,
    parameter int DATA_BITS = DATA_BITS_DEF,
    parameter int IDLE_BITS = IDLE_BITS_DEF
) (
    input  logic                 clk,
    input  logic                 por,
    input  logic                 sw_rst,
    input  logic                 baud_tick,
    input  logic                 wr_mode,
    input  logic [2:0]           mode_wdata,
    input  logic                 wr_ie,
    input  logic [1:0]           ie_wdata,
    input  logic                 wr_txdata,
    input  logic [DATA_BITS-1:0] tx_wdata,
    input  logic                 rd_rxdata,
    output logic [DATA_BITS-1:0] rx_data,
    input  logic                 rxd,
    output logic                 txd,
    output logic [2:0]           mode_q,
    output logic [1:0]           ie_q,
    output logic                 rx_flag,
    output logic                 tx_flag,
    output logic                 rx_irq,
    output logic                 tx_irq,
    output logic                 rx_active
);

    mode_t mode;
    ie_t   ie;
    logic  any_rst;
    logic  rx_done;
    logic  tx_load;

    assign any_rst = por || sw_rst;
    assign mode_q  = mode;
    assign ie_q    = ie;
    assign rx_irq  = rx_flag && ie.rx_ie;
    assign tx_irq  = tx_flag && ie.tx_ie;

    uart_irq_regs u_regs (
        .clk        (clk),
        .por        (por),
        .sw_rst     (sw_rst),
        .wr_mode    (wr_mode),
        .mode_wdata (mode_wdata),
        .wr_ie      (wr_ie),
        .ie_wdata   (ie_wdata),
        .rx_done    (rx_done),
        .rd_rx      (rd_rxdata),
        .tx_wr      (wr_txdata),
        .tx_load    (tx_load),
        .mode       (mode),
        .ie         (ie),
        .rx_flag    (rx_flag),
        .tx_flag    (tx_flag)
    );

    uart_irq_rx #(.OVS(OVS), .DATA_BITS(DATA_BITS), .IDLE_BITS(IDLE_BITS)) u_rx (
        .clk       (clk),
        .rst       (any_rst),
        .tick      (baud_tick),
        .en        (mode.rx_en),
        .idle_wait (mode.idle_wait),
        .rxd       (rxd),
        .done      (rx_done),
        .active    (rx_active),
        .data      (rx_data)
    );

    uart_irq_tx #(.OVS(OVS), .DATA_BITS(DATA_BITS)) u_tx (
        .clk   (clk),
        .rst   (any_rst),
        .tick  (baud_tick),
        .en    (mode.tx_en),
        .wr    (wr_txdata),
        .wdata (tx_wdata),
        .load  (tx_load),
        .txd   (txd)
    );

endmodule

// File: rtl/uart_irq_checker.sv
module uart_irq_checker (
    input logic       clk,
    input logic       por,
    input logic       sw_rst,
    input logic       wr_mode,
    input logic       wr_txdata,
    input logic [2:0] mode_q,
    input logic [1:0] ie_q,
    input logic       rx_flag,
    input logic       tx_flag,
    input logic       rx_active
);

    AST_SWRST_KEEPS_EN: assert property (@(posedge clk) disable iff (por)
        (sw_rst && !wr_mode) |=> $stable(mode_q)); // R2

    AST_SWRST_FLAGS: assert property (@(posedge clk) disable iff (por)
        sw_rst |=> (tx_flag && !rx_flag && ie_q == 2'b00)); // R2

    AST_RX_FLAG_AFTER_FRAME: assert property (@(posedge clk) disable iff (por || sw_rst)
        $rose(rx_flag) |-> $past(rx_active)); // R3

    AST_RX_OFF_STAYS: assert property (@(posedge clk) disable iff (por || sw_rst)
        (!mode_q[0] && !rx_active) |=> !rx_active); // R6

    AST_TX_WRITE_CLEARS: assert property (@(posedge clk) disable iff (por || sw_rst)
        wr_txdata |=> !tx_flag); // R8

    AST_TX_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (por || sw_rst)
        (!mode_q[1] && !tx_flag) |=> !tx_flag); // R8

endmodule

bind uart_irq_pair uart_irq_checker u_chk (
    .clk       (clk),
    .por       (por),
    .sw_rst    (sw_rst),
    .wr_mode   (wr_mode),
    .wr_txdata (wr_txdata),
    .mode_q    (mode_q),
    .ie_q      (ie_q),
    .rx_flag   (rx_flag),
    .tx_flag   (tx_flag),
    .rx_active (rx_active)
);

// File: tb/uart_irq_pair_bench.sv
`timescale 1ns/1ps
module uart_irq_pair_bench;

    localparam int BITCLK = 64; // 16 ticks, one every 4 clocks

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       sw_rst = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_mode = 1'b0;
    logic [2:0] mode_wdata = '0;
    logic       wr_ie = 1'b0;
    logic [1:0] ie_wdata = '0;
    logic       wr_txdata = 1'b0;
    logic [7:0] tx_wdata = '0;
    logic       rd_rxdata = 1'b0;
    logic [7:0] rx_data;
    logic       rxd = 1'b1;
    logic       txd;
    logic [2:0] mode_q;
    logic [1:0] ie_q;
    logic       rx_flag, tx_flag, rx_irq, tx_irq, rx_active;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    uart_irq_pair u_uart_irq_pair (
        .clk(clk), .por(por), .sw_rst(sw_rst), .baud_tick(baud_tick),
        .wr_mode(wr_mode), .mode_wdata(mode_wdata), .wr_ie(wr_ie), .ie_wdata(ie_wdata),
        .wr_txdata(wr_txdata), .tx_wdata(tx_wdata), .rd_rxdata(rd_rxdata),
        .rx_data(rx_data), .rxd(rxd), .txd(txd), .mode_q(mode_q), .ie_q(ie_q),
        .rx_flag(rx_flag), .tx_flag(tx_flag), .rx_irq(rx_irq), .tx_irq(tx_irq),
        .rx_active(rx_active)
    );

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic [2:0] v);
        wr_mode = 1'b1; mode_wdata = v;
        @(negedge clk);
        wr_mode = 1'b0;
    endtask

    task automatic set_ie(input logic [1:0] v);
        wr_ie = 1'b1; ie_wdata = v;
        @(negedge clk);
        wr_ie = 1'b0;
    endtask

    task automatic write_tx(input logic [7:0] v);
        wr_txdata = 1'b1; tx_wdata = v;
        @(negedge clk);
        wr_txdata = 1'b0;
    endtask

    task automatic read_rx();
        rd_rxdata = 1'b1;
        @(negedge clk);
        rd_rxdata = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] b);
        rxd = 1'b0; idle(BITCLK);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i]; idle(BITCLK);
        end
        rxd = 1'b1; idle(BITCLK);
    endtask

    task automatic capture_tx(output logic [7:0] b, output logic start_b, output logic stop_b);
        int wait_n = 0;
        while (txd !== 1'b0 && wait_n < 2000) begin
            @(negedge clk); wait_n++;
        end
        idle(BITCLK / 2);
        start_b = txd;
        for (int i = 0; i < 8; i++) begin
            idle(BITCLK); b[i] = txd;
        end
        idle(BITCLK);
        stop_b = txd;
    endtask

    task automatic t_reset();
        check("R1 mode_q", mode_q, 3'b000);
        check("R1 ie_q", ie_q, 2'b00);
        check("R1 rx_flag", rx_flag, 1'b0);
        check("R1 tx_flag", tx_flag, 1'b1);
        check("R1 txd idle", txd, 1'b1);
    endtask

    task automatic t_rx_basic();
        set_mode(3'b001);
        send_rx(8'h5A); idle(4);
        check("R3 flag set", rx_flag, 1'b1);
        check("R3 data 5A", rx_data, 8'h5A);
        read_rx();
        check("R3 read clears flag", rx_flag, 1'b0);
        send_rx(8'h81); idle(4);
        check("R3 data 81", rx_data, 8'h81);
        read_rx();
    endtask

    task automatic t_rx_glitch();
        rxd = 1'b0; idle(16);
        rxd = 1'b1; idle(100);
        check("R4 glitch not active", rx_active, 1'b0);
        check("R4 glitch no flag", rx_flag, 1'b0);
        send_rx(8'hC3); idle(4);
        check("R4 recovered data", rx_data, 8'hC3);
        read_rx();
    endtask

    task automatic t_rx_disabled();
        set_mode(3'b000);
        fork
            send_rx(8'h3C);
            begin idle(40); check("R6 off not active", rx_active, 1'b0); end
        join
        idle(4);
        check("R6 off no flag", rx_flag, 1'b0);
    endtask

    task automatic t_rx_disable_mid();
        set_mode(3'b001);
        fork
            send_rx(8'h96);
            begin
                idle(300); set_mode(3'b000);
                check("R5 still collecting", rx_active, 1'b1);
            end
        join
        idle(4);
        check("R5 char finished flag", rx_flag, 1'b1);
        check("R5 char finished data", rx_data, 8'h96);
        read_rx();
        send_rx(8'h11); idle(4);
        check("R5 later frame no flag", rx_flag, 1'b0);
        check("R5 later frame data kept", rx_data, 8'h96);
    endtask

    task automatic t_idle_wait();
        set_mode(3'b101);
        send_rx(8'h00);
        idle(200);
        send_rx(8'h00); idle(4);
        check("R7 short idle ignored", rx_flag, 1'b0);
        idle(700);
        send_rx(8'hE7); idle(4);
        check("R7 after quiet flag", rx_flag, 1'b1);
        check("R7 after quiet data", rx_data, 8'hE7);
        read_rx();
        set_mode(3'b000);
    endtask

    task automatic t_tx_flag();
        int n = 0;
        write_tx(8'h12);
        check("R8 write clears flag", tx_flag, 1'b0);
        idle(200);
        check("R8 disabled flag held", tx_flag, 1'b0);
        check("R8 disabled txd idle", txd, 1'b1);
        set_mode(3'b010);
        idle(1);
        check("R8 load sets flag", tx_flag, 1'b1);
        check("R9 start bit low", txd, 1'b0);
        write_tx(8'h34);
        check("R8 second write clears", tx_flag, 1'b0);
        idle(100);
        check("R8 busy keeps flag low", tx_flag, 1'b0);
        while (tx_flag !== 1'b1 && n < 1000) begin
            @(negedge clk); n++;
        end
        check("R8 flag after frame", tx_flag, 1'b1);
        idle(800);
    endtask

    task automatic t_duplex();
        logic [7:0] got;
        logic sb, pb;
        set_mode(3'b011);
        fork
            send_rx(8'hA5);
            begin write_tx(8'h3C); capture_tx(got, sb, pb); end
        join
        idle(4);
        check("R9 tx start", sb, 1'b0);
        check("R9 tx stop", pb, 1'b1);
        check("R11 tx byte", got, 8'h3C);
        check("R11 rx byte", rx_data, 8'hA5);
        read_rx();
        idle(200);
    endtask

    task automatic t_irq();
        set_ie(2'b00);
        check("R10 tx_irq masked", tx_irq, 1'b0);
        set_ie(2'b11);
        check("R10 tx_irq on", tx_irq, 1'b1);
        check("R10 rx_irq no flag", rx_irq, 1'b0);
        send_rx(8'h42); idle(4);
        check("R10 rx_irq on", rx_irq, 1'b1);
        set_ie(2'b10);
        check("R10 rx_irq masked", rx_irq, 1'b0);
    endtask

    task automatic t_swrst();
        set_ie(2'b11);
        write_tx(8'h55);
        idle(10);
        check("R9 sending start", txd, 1'b0);
        sw_rst = 1'b1; @(negedge clk); sw_rst = 1'b0;
        check("R2 mode kept", mode_q, 3'b011);
        check("R2 ie cleared", ie_q, 2'b00);
        check("R2 rx_flag cleared", rx_flag, 1'b0);
        check("R2 tx_flag set", tx_flag, 1'b1);
        check("R2 txd idle", txd, 1'b1);
        por = 1'b1; @(negedge clk); por = 1'b0;
        check("R1 por clears mode", mode_q, 3'b000);
        check("R1 por tx_flag", tx_flag, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(4);
        por = 1'b0;
        idle(1);
        t_reset();
        t_rx_basic();
        t_rx_glitch();
        t_rx_disabled();
        t_rx_disable_mid();
        t_idle_wait();
        t_tx_flag();
        t_duplex();
        t_irq();
        t_swrst();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule